// File: doc/BRIEF.md
# FFT Validity Tracker and Normalization Counter

This block sits between a channelizer and a correlator. Sample validity arrives once per sample for every input stream. The block folds it into one verdict per stream for each FFT. An FFT is good only if every sample in the window feeding it was good. The window reaches back across all the pre-filter taps, so one bad block spoils that many FFTs. After a new integration starts, the first FFTs are forced bad while the pre-filter fills. Each verdict is queued at the FFT boundary. It is then attached to the matching FFT when that FFT's bins leave the transform.

The bin stream passes through one register stage. Bins of a bad FFT are replaced by zero. The per-stream verdict is shown beside every bin from the first to the last. For every correlation product, meaning every pair of streams including a stream with itself, a saturating counter adds one per FFT in which both members are good. When the first FFT of a new integration reaches the output, the totals of the integration just finished are presented with a one-cycle strobe, and the counters restart. The integration length is therefore whatever number of FFTs the controller places between two start strobes.

Top module: `fftv_tracker`

## Requirements
- R1: If any sample of a stream is flagged invalid (samp_vld_i low while samp_stb_i is high) in the block that closes at an FFT boundary, that stream's FFT for this boundary is invalid.
- R2: A bad block keeps the stream's FFTs invalid for TAPS consecutive FFTs: the FFT that ends with it and the TAPS-1 after it. The FFT after that is valid again if nothing else is wrong.
- R3: The first FILL_FFTS FFTs after integ_start_i are invalid on every stream. If integ_start_i and fft_bound_i coincide, the FFT closed in that cycle counts as the first FFT of the new integration.
- R4: The output bin stream is the input bin stream delayed by exactly one cycle, with first and last flags kept. Stream s occupies bits [s*DW +: DW]. Its bins are zero when its FFT is invalid and unchanged when it is valid.
- R5: fft_ok_o bit s carries stream s's verdict for the FFT on the output. It is present on that FFT's first output bin and holds unchanged until its last.
- R6: Product p counts one per FFT in which both of its streams are valid. Products are numbered with a running from 0 and b from a up to NS-1. With NS=2 this gives p0=(0,0), p1=(0,1), p2=(1,1). Field p of rd_cnt_o is bits [p*CNT_W +: CNT_W].
- R7: When the first FFT of an integration reaches the output, rd_stb_o pulses on that first bin. In the same cycle rd_cnt_o shows the totals of the previous integration, and counting restarts from zero with this FFT.
- R8: Verdicts are applied in the order the FFTs were closed. A boundary and a first bin in the same cycle hand the older verdict to the output and queue the new one.
- R9: After reset the output is idle: out_vld_o, rd_stb_o, fft_ok_o and rd_cnt_o are zero.
- R10: samp_vld_i has no effect in cycles where samp_stb_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| integ_start_i | input | 1 | Start of a new integration |
| samp_stb_i | input | 1 | A sample is present on all streams |
| samp_vld_i | input | NS | Per-stream validity of the present sample |
| fft_bound_i | input | 1 | Closes the current sample block (its last sample, if any, is in this cycle) |
| bin_vld_i | input | 1 | A bin is present on all streams |
| bin_first_i | input | 1 | First bin of an FFT |
| bin_last_i | input | 1 | Last bin of an FFT |
| bin_data_i | input | NS*DW | Bins, stream s at [s*DW +: DW] |
| out_vld_o | output | 1 | Output bin present |
| out_first_o | output | 1 | First output bin of an FFT |
| out_last_o | output | 1 | Last output bin of an FFT |
| out_data_o | output | NS*DW | Gated bins |
| fft_ok_o | output | NS | Per-stream FFT verdict |
| rd_stb_o | output | 1 | Totals of the finished integration are valid |
| rd_cnt_o | output | NPROD*CNT_W | Per-product valid-FFT totals |

## Verification
Two functions can land on the same clock edge. One is closing a sample block, which pushes a verdict. The other is the first bin of an earlier FFT leaving, which pops a verdict and may also start the readout and clear the counters. The bench lines the boundary of block n+1 up exactly with the first bin of FFT n over several FFTs, and also puts an integration start on a boundary cycle. It then judges every output bin's gating, every held verdict and every readout against a reference model. That model keeps its own per-stream countdown of spoiled FFTs and its own FIFO of verdicts.

// File: rtl/fftv_pkg.sv
package fftv_pkg;

    // number of products among ns streams, each pair once plus self pairs
    function automatic int prod_total(input int ns);
        return ns * (ns + 1) / 2;
    endfunction

    // lower stream index of product p
    function automatic int prod_lo(input int ns, input int p);
        int idx;
        idx = 0;
        for (int a = 0; a < ns; a++) begin
            for (int b = a; b < ns; b++) begin
                if (idx == p) return a;
                idx++;
            end
        end
        return 0;
    endfunction

    // upper stream index of product p
    function automatic int prod_hi(input int ns, input int p);
        int idx;
        idx = 0;
        for (int a = 0; a < ns; a++) begin
            for (int b = a; b < ns; b++) begin
                if (idx == p) return b;
                idx++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/fftv_stream_hist.sv
// Per-stream block validity and tap window history.
module fftv_stream_hist #(
    parameter int TAPS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic integ_start_i,
    input  logic samp_stb_i,
    input  logic samp_vld_i,
    input  logic fft_bound_i,
    output logic win_ok_o
);
    localparam int HW = TAPS - 1;

    typedef struct packed {
        logic          acc;
        logic [HW-1:0] hist;
    } hist_t;

    hist_t st_d, st_q;
    logic  blk_ok;

    always_comb begin
        st_d = st_q;
        if (integ_start_i) begin
            st_d.acc  = 1'b1;
            st_d.hist = '1;
        end
        blk_ok   = st_d.acc & (~samp_stb_i | samp_vld_i);
        win_ok_o = (&st_d.hist) & blk_ok;
        if (fft_bound_i) begin
            st_d.hist = (st_d.hist << 1) | HW'(blk_ok);
            st_d.acc  = 1'b1;
        end else begin
            st_d.acc  = blk_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc  <= 1'b1;
            st_q.hist <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fftv_dec_fifo.sv
// Small FIFO of per-FFT verdicts; DEPTH must be a power of two, at least 2.
module fftv_dec_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] pop_data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [AW:0]             cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  pop_eff, push_eff;

    always_comb begin
        st_d       = st_q;
        empty_o    = (st_q.cnt == '0);
        full_o     = (st_q.cnt == (AW+1)'(DEPTH));
        pop_data_o = st_q.mem[st_q.rd];
        pop_eff    = pop_i & ~empty_o;
        push_eff   = push_i & (~full_o | pop_eff);
        if (push_eff) begin
            st_d.mem[st_q.wr] = push_data_i;
            st_d.wr           = st_q.wr + 1'b1;
        end
        if (pop_eff) st_d.rd = st_q.rd + 1'b1;
        case ({push_eff, pop_eff})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem <= '0;
            st_q.wr  <= '0;
            st_q.rd  <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fftv_prod_acc.sv
// One saturating valid-FFT counter with a readout latch.
module fftv_prod_acc #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] rd_cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rd;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.rd  = st_q.cnt;
            st_d.cnt = '0;
        end
        if (inc_i && st_d.cnt != '1) st_d.cnt = st_d.cnt + 1'b1;
        rd_cnt_o = st_q.rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.rd  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fftv_tracker.sv
module fftv_tracker #(
    parameter int NS        = 4,
    parameter int DW        = 16,
    parameter int TAPS      = 6,
    parameter int FILL_FFTS = 6,
    parameter int QDEPTH    = 4,
    parameter int CNT_W     = 32,
    localparam int NPROD    = fftv_pkg::prod_total(NS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   integ_start_i,
    input  logic                   samp_stb_i,
    input  logic [NS-1:0]          samp_vld_i,
    input  logic                   fft_bound_i,
    input  logic                   bin_vld_i,
    input  logic                   bin_first_i,
    input  logic                   bin_last_i,
    input  logic [NS*DW-1:0]       bin_data_i,
    output logic                   out_vld_o,
    output logic                   out_first_o,
    output logic                   out_last_o,
    output logic [NS*DW-1:0]       out_data_o,
    output logic [NS-1:0]          fft_ok_o,
    output logic                   rd_stb_o,
    output logic [NPROD*CNT_W-1:0] rd_cnt_o
);
    localparam int FW = $clog2(FILL_FFTS + 1);
    localparam int QW = NS + 1;

    typedef struct packed {
        logic [FW-1:0]    fill;
        logic             pend;
        logic [NS-1:0]    cur_ok;
        logic             out_vld;
        logic             out_first;
        logic             out_last;
        logic [NS*DW-1:0] out_data;
        logic [NS-1:0]    out_ok;
        logic             rd_stb;
    } top_t;

    top_t            st_d, st_q;
    logic [NS-1:0]   hist_ok;
    logic [FW-1:0]   fill_base;
    logic            pend_base;
    logic            fill_done;
    logic [QW-1:0]   q_wdata;
    logic [QW-1:0]   q_rdata;
    logic            q_pop;
    logic            q_empty;
    logic            q_full;
    logic [NS-1:0]   eff_ok;
    logic            tag_pop;
    logic [NPROD-1:0] prod_inc;

    for (genvar s = 0; s < NS; s++) begin : g_strm
        fftv_stream_hist #(.TAPS(TAPS)) u_hist (
            .clk           (clk),
            .rst_n         (rst_n),
            .integ_start_i (integ_start_i),
            .samp_stb_i    (samp_stb_i),
            .samp_vld_i    (samp_vld_i[s]),
            .fft_bound_i   (fft_bound_i),
            .win_ok_o      (hist_ok[s])
        );
    end

    fftv_dec_fifo #(.W(QW), .DEPTH(QDEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (fft_bound_i),
        .push_data_i (q_wdata),
        .pop_i       (q_pop),
        .pop_data_o  (q_rdata),
        .empty_o     (q_empty),
        .full_o      (q_full)
    );

    always_comb begin
        st_d      = st_q;
        fill_base = integ_start_i ? '0 : st_q.fill;
        pend_base = integ_start_i | st_q.pend;
        fill_done = (fill_base >= FW'(FILL_FFTS));
        q_wdata   = {pend_base, hist_ok & {NS{fill_done}}};
        st_d.fill = fill_base;
        st_d.pend = pend_base;
        if (fft_bound_i) begin
            st_d.pend = 1'b0;
            if (!fill_done) st_d.fill = fill_base + 1'b1;
        end

        q_pop   = bin_vld_i & bin_first_i;
        eff_ok  = st_q.cur_ok;
        tag_pop = 1'b0;
        if (q_pop) begin
            eff_ok  = q_empty ? '0 : q_rdata[NS-1:0];
            tag_pop = ~q_empty & q_rdata[NS];
        end
        st_d.cur_ok    = eff_ok;
        st_d.out_vld   = bin_vld_i;
        st_d.out_first = bin_vld_i & bin_first_i;
        st_d.out_last  = bin_vld_i & bin_last_i;
        if (bin_vld_i) begin
            st_d.out_ok = eff_ok;
            for (int s = 0; s < NS; s++) begin
                st_d.out_data[s*DW +: DW] = eff_ok[s] ? bin_data_i[s*DW +: DW] : '0;
            end
        end
        st_d.rd_stb = tag_pop;
    end

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        localparam int PA = fftv_pkg::prod_lo(NS, p);
        localparam int PB = fftv_pkg::prod_hi(NS, p);
        assign prod_inc[p] = bin_vld_i & bin_last_i & eff_ok[PA] & eff_ok[PB];
        fftv_prod_acc #(.CNT_W(CNT_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (tag_pop),
            .inc_i    (prod_inc[p]),
            .rd_cnt_o (rd_cnt_o[p*CNT_W +: CNT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld_o   = st_q.out_vld;
    assign out_first_o = st_q.out_first;
    assign out_last_o  = st_q.out_last;
    assign out_data_o  = st_q.out_data;
    assign fft_ok_o    = st_q.out_ok;
    assign rd_stb_o    = st_q.rd_stb;
endmodule

// File: rtl/fftv_tracker_chk.sv
module fftv_tracker_chk #(
    parameter int NS = 4,
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bin_vld_i,
    input logic             bin_first_i,
    input logic             fft_bound_i,
    input logic             q_full,
    input logic             q_pop,
    input logic             out_vld_o,
    input logic             out_first_o,
    input logic [NS*DW-1:0] out_data_o,
    input logic [NS-1:0]    fft_ok_o,
    input logic             rd_stb_o
);
    for (genvar s = 0; s < NS; s++) begin : g_zero
        AST_ZERO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld_o && !fft_ok_o[s]) |-> (out_data_o[s*DW +: DW] == '0)); // R4
    end

    AST_BIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        bin_vld_i |=> (out_vld_o && out_first_o == $past(bin_first_i))); // R4

    AST_OK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && !out_first_o) |-> $stable(fft_ok_o)); // R5

    AST_RD_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |-> (out_vld_o && out_first_o)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fft_bound_i && q_full) |-> q_pop); // R8
endmodule

bind fftv_tracker fftv_tracker_chk #(.NS(NS), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bin_vld_i   (bin_vld_i),
    .bin_first_i (bin_first_i),
    .fft_bound_i (fft_bound_i),
    .q_full      (q_full),
    .q_pop       (q_pop),
    .out_vld_o   (out_vld_o),
    .out_first_o (out_first_o),
    .out_data_o  (out_data_o),
    .fft_ok_o    (fft_ok_o),
    .rd_stb_o    (rd_stb_o)
);

// File: tb/fftv_tracker_bench.sv
`timescale 1ns/1ps
module fftv_tracker_bench;
    localparam int NS    = 2;
    localparam int DW    = 8;
    localparam int TAPS  = 6;
    localparam int FILL  = 6;
    localparam int CNT_W = 32;
    localparam int NPROD = NS * (NS + 1) / 2;
    localparam int BLK   = 4;
    localparam int NBINS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic integ_start_i = 0, samp_stb_i = 0, fft_bound_i = 0;
    logic [NS-1:0] samp_vld_i = '0;
    logic bin_vld_i = 0, bin_first_i = 0, bin_last_i = 0;
    logic [NS*DW-1:0] bin_data_i = '0;
    logic out_vld_o, out_first_o, out_last_o, rd_stb_o;
    logic [NS*DW-1:0] out_data_o;
    logic [NS-1:0] fft_ok_o;
    logic [NPROD*CNT_W-1:0] rd_cnt_o;

    always #2.5 clk = ~clk;

    fftv_tracker #(.NS(NS), .DW(DW), .TAPS(TAPS), .FILL_FFTS(FILL),
                   .QDEPTH(4), .CNT_W(CNT_W)) u_fftv_tracker (
        .clk(clk), .rst_n(rst_n), .integ_start_i(integ_start_i),
        .samp_stb_i(samp_stb_i), .samp_vld_i(samp_vld_i),
        .fft_bound_i(fft_bound_i), .bin_vld_i(bin_vld_i),
        .bin_first_i(bin_first_i), .bin_last_i(bin_last_i),
        .bin_data_i(bin_data_i), .out_vld_o(out_vld_o),
        .out_first_o(out_first_o), .out_last_o(out_last_o),
        .out_data_o(out_data_o), .fft_ok_o(fft_ok_o),
        .rd_stb_o(rd_stb_o), .rd_cnt_o(rd_cnt_o));

    typedef struct {
        logic [NS-1:0] ok;
        bit            first;
        string         req;
    } dec_t;

    typedef struct {
        logic [NS*DW-1:0]       data;
        logic [NS-1:0]          ok;
        bit                     first, last, rd;
        logic [NPROD*CNT_W-1:0] rdv;
        string                  req;
    } exp_t;

    dec_t dq[$];
    exp_t exp_q[$];
    int nchk = 0, nfail = 0;
    bit done = 0;
    int fill = 0;
    bit pend = 0;
    int bl[NS];
    int mcnt[NPROD];
    int pa[NPROD], pb[NPROD];

    function automatic void chk(input bit c, input string m);
        nchk++;
        if (!c) begin
            nfail++;
            $display("FAIL %s", m);
        end
    endfunction

    task automatic idle();
        integ_start_i = 0; samp_stb_i = 0; samp_vld_i = '0; fft_bound_i = 0;
        bin_vld_i = 0; bin_first_i = 0; bin_last_i = 0; bin_data_i = '0;
    endtask

    // reference verdict for the FFT closed now
    task automatic model_bound(input logic [NS-1:0] bad, input bit start,
                               input bit gap, input bit ovl);
        dec_t d;
        bit any_bad_ok;
        if (start) begin
            fill = 0; pend = 1;
            for (int s = 0; s < NS; s++) bl[s] = 0;
        end
        d.first = pend; pend = 0;
        any_bad_ok = 0;
        for (int s = 0; s < NS; s++) begin
            if (bad[s]) bl[s] = TAPS;
            d.ok[s] = (bl[s] == 0) && (fill >= FILL);
            if (!d.ok[s]) any_bad_ok = 1;
            if (bl[s] > 0) bl[s]--;
        end
        if (fill < FILL)     d.req = "R3";
        else if (bad != 0)   d.req = "R1";
        else if (any_bad_ok) d.req = "R2";
        else if (gap)        d.req = "R10";
        else if (ovl)        d.req = "R8";
        else                 d.req = "R5";
        if (fill < FILL) fill++;
        dq.push_back(d);
    endtask

    task automatic set_bin(input int k, input dec_t d);
        exp_t e;
        logic [NS*DW-1:0] dat;
        dat = NS*DW'($urandom);
        bin_vld_i = 1; bin_first_i = (k == 0); bin_last_i = (k == NBINS-1);
        bin_data_i = dat;
        for (int s = 0; s < NS; s++)
            e.data[s*DW +: DW] = d.ok[s] ? dat[s*DW +: DW] : '0;
        e.ok = d.ok; e.first = (k == 0); e.last = (k == NBINS-1);
        e.rd = (k == 0) && d.first; e.rdv = '0; e.req = d.req;
        if (e.rd) begin
            for (int p = 0; p < NPROD; p++) begin
                e.rdv[p*CNT_W +: CNT_W] = CNT_W'(mcnt[p]);
                mcnt[p] = 0;
            end
        end
        if (e.last) begin
            for (int p = 0; p < NPROD; p++)
                if (d.ok[pa[p]] && d.ok[pb[p]]) mcnt[p]++;
        end
        exp_q.push_back(e);
    endtask

    task automatic samp_block(input logic [NS-1:0] bad, input int start_at,
                              input bit gap, input bit ovl);
        dec_t cur;
        for (int i = 0; i < BLK; i++) begin
            @(negedge clk);
            idle();
            integ_start_i = (i == start_at);
            if (gap && i == 1) begin
                samp_stb_i = 0; samp_vld_i = '0;
            end else begin
                samp_stb_i = 1;
                for (int s = 0; s < NS; s++) samp_vld_i[s] = !(bad[s] && i == 2);
            end
            if (i == BLK-1) begin
                fft_bound_i = 1;
                model_bound(bad, start_at >= 0, gap, ovl);
                if (ovl) begin
                    cur = dq.pop_front();
                    set_bin(0, cur);
                end
            end
        end
        if (ovl) begin
            for (int k = 1; k < NBINS; k++) begin
                @(negedge clk);
                idle();
                set_bin(k, cur);
            end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic run_bins();
        dec_t cur;
        cur = dq.pop_front();
        for (int k = 0; k < NBINS; k++) begin
            @(negedge clk);
            idle();
            set_bin(k, cur);
        end
        @(negedge clk);
        idle();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_vld_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected output bin act=1 exp=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(out_data_o == e.data, $sformatf("R4 data act=%h exp=%h", out_data_o, e.data));
                    chk(fft_ok_o == e.ok, $sformatf("%s verdict act=%b exp=%b", e.req, fft_ok_o, e.ok));
                    chk(out_first_o == e.first && out_last_o == e.last,
                        $sformatf("R4 flags act=%b%b exp=%b%b", out_first_o, out_last_o, e.first, e.last));
                    chk(rd_stb_o == e.rd, $sformatf("R7 strobe act=%b exp=%b", rd_stb_o, e.rd));
                    if (e.rd)
                        chk(rd_cnt_o == e.rdv, $sformatf("R6 R7 totals act=%h exp=%h", rd_cnt_o, e.rdv));
                end
            end else if (rd_stb_o) begin
                chk(0, "R7 strobe without bin act=1 exp=0");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        begin
            int idx;
            idx = 0;
            for (int a = 0; a < NS; a++)
                for (int b = a; b < NS; b++) begin
                    pa[idx] = a; pb[idx] = b; idx++;
                end
        end
        for (int s = 0; s < NS; s++) bl[s] = 0;
        for (int p = 0; p < NPROD; p++) mcnt[p] = 0;
        idle();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(out_vld_o == 0 && rd_stb_o == 0 && fft_ok_o == '0 && rd_cnt_o == '0,
            $sformatf("R9 reset state act=%b%b%b%h exp=0", out_vld_o, rd_stb_o, fft_ok_o, rd_cnt_o));

        // integration A: start on first sample, one block and one FFT at a time
        for (int k = 0; k < 17; k++) begin
            logic [NS-1:0] bad;
            bad = '0;
            if (k == 7) bad[0] = 1;
            if (k == 9) bad[1] = 1;
            samp_block(bad, (k == 0) ? 0 : -1, k == 16, 0);
            run_bins();
        end

        // integration B: start shares the boundary cycle, then overlapped
        for (int k = 0; k < 10; k++) begin
            logic [NS-1:0] bad;
            bad = '0;
            if (k == 8) bad[1] = 1;
            samp_block(bad, (k == 0) ? BLK-1 : -1, 0, k >= 1);
        end
        run_bins();

        // integration C: flushes B's totals
        samp_block('0, 0, 0, 0);
        run_bins();

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, $sformatf("R4 pending bins act=%0d exp=0", exp_q.size()));
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule